// File: doc/BRIEF.md
# Host Command Dispatcher with Seconds Clock

This block sits behind a byte-serial transfer engine. It takes a finished host packet and reads the packet type and the command byte. It carries out the command and hands back a complete reply packet in one flat byte vector with a length. Byte 0 of every packet is its type: 0 is a peripheral-bus packet, 1 is a controller command and 2 is an error report. Types 3 to 6 (timer, power, I2C and power-manager traffic) are accepted and get no answer.

The block holds several pieces of state. A 32-bit seconds clock counts from a 1904 epoch and is advanced by a prescaler on the system clock. The autopoll enable, autopoll rate and device-mask registers drive an external peripheral-bus poller. Power-down and system-reset request pulses go out to the rest of the chip. Peripheral-bus packets are passed to an external bus engine. Its completion comes back as a reply packet. Autopoll results from the poller come back as report packets.

Top module: `host_cmd_dispatch`

## Requirements
- R1: After reset, autopoll is off, the rate register holds 11, the device mask holds 0, no reply is pending, and the seconds clock holds 2082844800 plus the configured Unix start time (0x7C25B080 by default).
- R2: A request whose reply is produced appears on the reply port one clock after the request edge, with the reply valid flag high for exactly that one cycle.
- R3: A command (type 1, length at least 2) that is known and has the right argument count replies with the bytes 1, 0, the command byte, then any result bytes.
- R4: An unknown command code replies with the four bytes 2, 0x02, 1, command byte. The known codes are 0x01 autopoll, 0x03 get-time, 0x09 set-time, 0x0A power-down, 0x0E file-server flag, 0x11 system reset, 0x14 rate, 0x19 device list and 0x21 power messages.
- R5: A known command whose argument count (length minus 2) is not exactly its required count replies with 2, 0x05, 1, command byte. A rate argument of 0 gets the same reply.
- R6: Get-time takes 0 arguments and returns the seconds value as bytes 3 to 6, most significant first. Set-time takes 4 arguments in that same order and loads the clock.
- R7: The seconds clock advances by one every TICK_DIV clocks, and set-time restarts the prescaler.
- R8: Autopoll takes one byte, and any nonzero value enables. Rate takes one byte. Device list takes two bytes, high byte first. A rejected command changes no register.
- R9: Power-down (0 arguments) and system reset (0 arguments) each pulse their request output for the cycle of their reply. File-server flag and power messages (1 argument each) are acknowledged and change no state.
- R10: A type-0 packet of length at least 2 pulses bus_go with bus_cmd equal to byte 1 and makes no immediate reply. A bus completion with code 0 replies 0, 0x00, data bytes. A nonzero code replies 0, code, and the saved command byte.
- R11: A poll result replies 0, 0x40, then the polled bytes, but only while autopoll is enabled. Otherwise it is ignored.
- R12: Packets of types other than 1 and 0, and command packets shorter than 2 bytes, produce no reply.
- R13: When events coincide in one cycle, a request wins over a bus completion, and a bus completion wins over a poll result. The losers are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Completed host packet present this cycle |
| req_len | input | LENW | Packet length in bytes |
| req_data | input | REQ_BYTES*8 | Packet bytes, byte 0 in bits 7:0 |
| bus_go | output | 1 | One-cycle start for the peripheral-bus engine |
| bus_cmd | output | 8 | Bus command byte (packet byte 1) |
| bus_args | output | (REQ_BYTES-2)*8 | Remaining bus packet bytes |
| bus_argc | output | LENW | Number of valid bytes in bus_args |
| bus_done | input | 1 | Bus engine completion |
| bus_code | input | 8 | Completion code, 0 means success |
| bus_len | input | PLW | Number of reply data bytes from the bus |
| bus_data | input | POLL_BYTES*8 | Bus reply data, first byte in bits 7:0 |
| poll_valid | input | 1 | Autopoll result present |
| poll_len | input | PLW | Number of polled bytes |
| poll_data | input | POLL_BYTES*8 | Polled bytes, first byte in bits 7:0 |
| rsp_valid | output | 1 | Reply packet valid, one cycle |
| rsp_len | output | RLW | Reply length in bytes |
| rsp_data | output | RSP_BYTES*8 | Reply bytes, byte 0 in bits 7:0 |
| ap_enable | output | 1 | Autopoll enable |
| ap_rate | output | 8 | Autopoll period in milliseconds |
| ap_mask | output | 16 | Autopoll device mask |
| pwr_down_req | output | 1 | Power-down request pulse |
| sys_reset_req | output | 1 | System reset request pulse |

## Verification
The bench targets the argument-count edges: one byte too few or too many for autopoll, device list, get-time and power messages, plus a rate of zero. A design that counted the type byte or the command byte as an argument would acknowledge bad packets, or reject good ones and leave the registers unchanged. Byte order is checked on set-time followed by get-time and on the device mask, where a swapped order shows up as a reversed value. The bench also covers several cases that a wrong design fails in a visible way:
- Wrong priority leaks a poll report or a bus reply in the cycle after a request.
- Reporting while autopoll is off produces an unexpected reply.
- A prescaler that is not restarted by set-time gives the wrong tick count after a known wait.
- A bus failure that loses the saved command byte gives a wrong third reply byte.

// File: rtl/hce_pkg.sv
// Package: shared codes and the action record passed from the decoder to
// the state registers of the host command dispatcher.
package hce_pkg;
    localparam logic [7:0] PT_BUS  = 8'd0;
    localparam logic [7:0] PT_CTRL = 8'd1;
    localparam logic [7:0] PT_ERR  = 8'd2;

    localparam logic [7:0] ERR_UNKNOWN = 8'h02;
    localparam logic [7:0] ERR_ARGS    = 8'h05;
    localparam logic [7:0] AP_REPORT   = 8'h40;

    localparam logic [7:0] CMD_AUTOPOLL  = 8'h01;
    localparam logic [7:0] CMD_GET_TIME  = 8'h03;
    localparam logic [7:0] CMD_SET_TIME  = 8'h09;
    localparam logic [7:0] CMD_POWER_OFF = 8'h0A;
    localparam logic [7:0] CMD_FS_FLAG   = 8'h0E;
    localparam logic [7:0] CMD_SYS_RESET = 8'h11;
    localparam logic [7:0] CMD_RATE      = 8'h14;
    localparam logic [7:0] CMD_DEV_LIST  = 8'h19;
    localparam logic [7:0] CMD_PWR_MSG   = 8'h21;

    // Seconds between the 1904 and 1970 epochs
    localparam logic [31:0] EPOCH_SHIFT = 32'd2082844800;

    typedef struct packed {
        logic        ap_wr;
        logic        ap_val;
        logic        rate_wr;
        logic [7:0]  rate_val;
        logic        mask_wr;
        logic [15:0] mask_val;
        logic        time_wr;
        logic [31:0] time_val;
        logic        pwr;
        logic        sysrst;
    } act_t;
endpackage

// File: rtl/hce_rtc.sv
// Seconds clock: a prescaler divides clk by TICK_DIV and advances a 32-bit
// seconds count. A load sets the count and restarts the prescaler.
// Assumes TICK_DIV >= 1.
module hce_rtc #(
    parameter int unsigned  TICK_DIV = 50_000_000,
    parameter logic [31:0]  SEC_INIT = 32'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld,
    input  logic [31:0] ld_val,
    output logic [31:0] sec
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [PW-1:0] pre;
    logic          tick;

    assign tick = (pre == PW'(TICK_DIV - 1));

    // Prescaler and seconds count, load has priority over the tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre <= '0;
            sec <= SEC_INIT;
        end else if (ld) begin
            pre <= '0;
            sec <= ld_val;
        end else if (tick) begin
            pre <= '0;
            sec <= sec + 32'd1;
        end else begin
            pre <= pre + PW'(1);
        end
    end

    AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> (sec == $past(sec) || sec == $past(sec) + 32'd1)); // R7
    AST_SEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> sec == $past(ld_val)); // R6
endmodule

// File: rtl/hce_decode.sv
// Command decoder: combinational. It checks a type-1 packet, builds the
// success or error reply and lists the state updates to apply. Only packet
// bytes 0..5 matter to it. Assumes RSP_BYTES >= 7.
module hce_decode
    import hce_pkg::*;
#(
    parameter int LENW      = 5,
    parameter int RSP_BYTES = 16,
    localparam int RLW      = $clog2(RSP_BYTES + 1)
) (
    input  logic [LENW-1:0]        len,
    input  logic [47:0]            pkt,
    input  logic [31:0]            sec,
    output logic                   reply,
    output logic [RLW-1:0]         rlen,
    output logic [RSP_BYTES*8-1:0] rsp,
    output act_t                   act
);
    logic [7:0]      cmd, a0, a1, a2, a3;
    logic [LENW-1:0] nargs;
    logic            known, good;

    assign cmd   = pkt[15:8];
    assign a0    = pkt[23:16];
    assign a1    = pkt[31:24];
    assign a2    = pkt[39:32];
    assign a3    = pkt[47:40];
    assign nargs = len - LENW'(2);

    // Validate the command and form its reply and actions
    always_comb begin
        reply = 1'b0;
        rlen  = '0;
        rsp   = '0;
        act   = '0;
        known = 1'b1;
        good  = 1'b0;
        if (pkt[7:0] == PT_CTRL && len >= LENW'(2)) begin
            reply = 1'b1;
            case (cmd)
                CMD_AUTOPOLL: begin
                    good       = (nargs == LENW'(1));
                    act.ap_wr  = good;
                    act.ap_val = (a0 != 8'd0);
                end
                CMD_GET_TIME:  good = (nargs == LENW'(0));
                CMD_SET_TIME: begin
                    good         = (nargs == LENW'(4));
                    act.time_wr  = good;
                    act.time_val = {a0, a1, a2, a3};
                end
                CMD_POWER_OFF: begin
                    good    = (nargs == LENW'(0));
                    act.pwr = good;
                end
                CMD_FS_FLAG, CMD_PWR_MSG: good = (nargs == LENW'(1));
                CMD_SYS_RESET: begin
                    good       = (nargs == LENW'(0));
                    act.sysrst = good;
                end
                CMD_RATE: begin
                    good         = (nargs == LENW'(1)) && (a0 != 8'd0);
                    act.rate_wr  = good;
                    act.rate_val = a0;
                end
                CMD_DEV_LIST: begin
                    good         = (nargs == LENW'(2));
                    act.mask_wr  = good;
                    act.mask_val = {a0, a1};
                end
                default: known = 1'b0;
            endcase
            if (!known) begin
                rsp[31:0] = {cmd, PT_CTRL, ERR_UNKNOWN, PT_ERR};
                rlen      = RLW'(4);
            end else if (!good) begin
                rsp[31:0] = {cmd, PT_CTRL, ERR_ARGS, PT_ERR};
                rlen      = RLW'(4);
            end else begin
                rsp[23:0] = {cmd, 8'h00, PT_CTRL};
                rlen      = RLW'(3);
                if (cmd == CMD_GET_TIME) begin
                    rsp[55:24] = {sec[7:0], sec[15:8], sec[23:16], sec[31:24]};
                    rlen       = RLW'(7);
                end
            end
        end
    end
endmodule

// File: rtl/host_cmd_dispatch.sv
// Host command dispatcher: runs controller commands, forwards peripheral-bus
// packets, formats bus completions and autopoll reports, and holds the
// autopoll registers and the seconds clock. Assumes REQ_BYTES >= 6,
// RSP_BYTES >= 7 and POLL_BYTES + 2 <= RSP_BYTES.
module host_cmd_dispatch
    import hce_pkg::*;
#(
    parameter int unsigned TICK_DIV   = 50_000_000,
    parameter logic [31:0] UNIX_INIT  = 32'd0,
    parameter int          REQ_BYTES  = 16,
    parameter int          RSP_BYTES  = 16,
    parameter int          POLL_BYTES = 8,
    parameter logic [7:0]  RATE_INIT  = 8'd11,
    localparam int LENW = $clog2(REQ_BYTES + 1),
    localparam int RLW  = $clog2(RSP_BYTES + 1),
    localparam int PLW  = $clog2(POLL_BYTES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [LENW-1:0]            req_len,
    input  logic [REQ_BYTES*8-1:0]     req_data,
    output logic                       bus_go,
    output logic [7:0]                 bus_cmd,
    output logic [(REQ_BYTES-2)*8-1:0] bus_args,
    output logic [LENW-1:0]            bus_argc,
    input  logic                       bus_done,
    input  logic [7:0]                 bus_code,
    input  logic [PLW-1:0]             bus_len,
    input  logic [POLL_BYTES*8-1:0]    bus_data,
    input  logic                       poll_valid,
    input  logic [PLW-1:0]             poll_len,
    input  logic [POLL_BYTES*8-1:0]    poll_data,
    output logic                       rsp_valid,
    output logic [RLW-1:0]             rsp_len,
    output logic [RSP_BYTES*8-1:0]     rsp_data,
    output logic                       ap_enable,
    output logic [7:0]                 ap_rate,
    output logic [15:0]                ap_mask,
    output logic                       pwr_down_req,
    output logic                       sys_reset_req
);
    typedef logic [RSP_BYTES*8-1:0] buf_t;

    logic           dec_reply, apply, is_bus_req, nxt_v;
    logic [RLW-1:0] dec_len, nxt_len;
    buf_t           dec_rsp, nxt_data;
    act_t           act;
    logic [31:0]    sec;

    hce_rtc #(.TICK_DIV(TICK_DIV), .SEC_INIT(EPOCH_SHIFT + UNIX_INIT)) u_rtc (
        .clk(clk), .rst_n(rst_n), .ld(apply && act.time_wr),
        .ld_val(act.time_val), .sec(sec)
    );

    hce_decode #(.LENW(LENW), .RSP_BYTES(RSP_BYTES)) u_dec (
        .len(req_len), .pkt(req_data[47:0]), .sec(sec),
        .reply(dec_reply), .rlen(dec_len), .rsp(dec_rsp), .act(act)
    );

    assign apply      = req_valid && dec_reply;
    assign is_bus_req = req_valid && req_data[7:0] == PT_BUS && req_len >= LENW'(2);

    // Pick the reply source: request, then bus completion, then poll result
    always_comb begin
        nxt_v    = 1'b0;
        nxt_len  = '0;
        nxt_data = '0;
        if (req_valid) begin
            nxt_v    = dec_reply;
            nxt_len  = dec_len;
            nxt_data = dec_rsp;
        end else if (bus_done) begin
            nxt_v = 1'b1;
            if (bus_code == 8'd0) begin
                nxt_data = buf_t'({bus_data, 8'h00, PT_BUS});
                nxt_len  = RLW'(bus_len) + RLW'(2);
            end else begin
                nxt_data = buf_t'({bus_cmd, bus_code, PT_BUS});
                nxt_len  = RLW'(3);
            end
        end else if (poll_valid && ap_enable) begin
            nxt_v    = 1'b1;
            nxt_data = buf_t'({poll_data, AP_REPORT, PT_BUS});
            nxt_len  = RLW'(poll_len) + RLW'(2);
        end
    end

    // Register the reply, the request pulses and the bus hand-off
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_len       <= '0;
            rsp_data      <= '0;
            pwr_down_req  <= 1'b0;
            sys_reset_req <= 1'b0;
            bus_go        <= 1'b0;
            bus_cmd       <= '0;
            bus_args      <= '0;
            bus_argc      <= '0;
        end else begin
            rsp_valid     <= nxt_v;
            rsp_len       <= nxt_len;
            rsp_data      <= nxt_data;
            pwr_down_req  <= apply && act.pwr;
            sys_reset_req <= apply && act.sysrst;
            bus_go        <= is_bus_req;
            if (is_bus_req) begin
                bus_cmd  <= req_data[15:8];
                bus_args <= req_data[REQ_BYTES*8-1:16];
                bus_argc <= req_len - LENW'(2);
            end
        end
    end

    // Autopoll configuration registers, written only by accepted commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ap_enable <= 1'b0;
            ap_rate   <= RATE_INIT;
            ap_mask   <= 16'h0000;
        end else if (apply) begin
            if (act.ap_wr)   ap_enable <= act.ap_val;
            if (act.rate_wr) ap_rate   <= act.rate_val;
            if (act.mask_wr) ap_mask   <= act.mask_val;
        end
    end

    AST_AP_OFF_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !ap_enable); // R1
    AST_CTRL_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_data[7:0] == PT_CTRL && req_len >= LENW'(2))
        |=> rsp_valid && (rsp_data[7:0] == PT_CTRL || rsp_data[7:0] == PT_ERR)); // R3
    AST_ERR_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_data[7:0] == PT_ERR) |-> rsp_len == RLW'(4)); // R4
    AST_PULSE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_down_req || sys_reset_req) |-> rsp_valid && rsp_data[7:0] == PT_CTRL); // R9
    AST_POLL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_valid && !ap_enable && !req_valid && !bus_done) |=> !rsp_valid); // R11
    AST_OTHER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_data[7:0] != PT_CTRL) |=> !rsp_valid); // R12
endmodule

// File: tb/host_cmd_dispatch_test.sv
module host_cmd_dispatch_test;
    localparam int TDIV = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [4:0]    req_len = '0;
    logic [127:0]  req_data = '0;
    logic          bus_go;
    logic [7:0]    bus_cmd;
    logic [111:0]  bus_args;
    logic [4:0]    bus_argc;
    logic          bus_done = 1'b0;
    logic [7:0]    bus_code = '0;
    logic [3:0]    bus_len = '0;
    logic [63:0]   bus_data = '0;
    logic          poll_valid = 1'b0;
    logic [3:0]    poll_len = '0;
    logic [63:0]   poll_data = '0;
    logic          rsp_valid;
    logic [4:0]    rsp_len;
    logic [127:0]  rsp_data;
    logic          ap_enable;
    logic [7:0]    ap_rate;
    logic [15:0]   ap_mask;
    logic          pwr_down_req, sys_reset_req;

    int nchk = 0;
    int nbad = 0;
    logic [7:0] tx[16];
    logic [4:0] tx_len;

    always #10 clk = ~clk;

    host_cmd_dispatch #(.TICK_DIV(TDIV)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
        .req_data(req_data), .bus_go(bus_go), .bus_cmd(bus_cmd),
        .bus_args(bus_args), .bus_argc(bus_argc), .bus_done(bus_done),
        .bus_code(bus_code), .bus_len(bus_len), .bus_data(bus_data),
        .poll_valid(poll_valid), .poll_len(poll_len), .poll_data(poll_data),
        .rsp_valid(rsp_valid), .rsp_len(rsp_len), .rsp_data(rsp_data),
        .ap_enable(ap_enable), .ap_rate(ap_rate), .ap_mask(ap_mask),
        .pwr_down_req(pwr_down_req), .sys_reset_req(sys_reset_req)
    );

    typedef struct packed {
        logic [4:0]       len;
        logic [0:7][7:0]  d;
        logic [4:0]       elen;
        logic [0:7][7:0]  e;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{5'd3, '{8'h01,8'h01,8'h05,8'h00,8'h00,8'h00,8'h00,8'h00}, 5'd3, '{8'h01,8'h00,8'h01,8'h00,8'h00,8'h00,8'h00,8'h00}},
        '{5'd3, '{8'h01,8'h14,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}, 5'd4, '{8'h02,8'h05,8'h01,8'h14,8'h00,8'h00,8'h00,8'h00}},
        '{5'd3, '{8'h01,8'h14,8'h20,8'h00,8'h00,8'h00,8'h00,8'h00}, 5'd3, '{8'h01,8'h00,8'h14,8'h00,8'h00,8'h00,8'h00,8'h00}},
        '{5'd4, '{8'h01,8'h19,8'hA5,8'h3C,8'h00,8'h00,8'h00,8'h00}, 5'd3, '{8'h01,8'h00,8'h19,8'h00,8'h00,8'h00,8'h00,8'h00}},
        '{5'd3, '{8'h01,8'h19,8'hA5,8'h00,8'h00,8'h00,8'h00,8'h00}, 5'd4, '{8'h02,8'h05,8'h01,8'h19,8'h00,8'h00,8'h00,8'h00}},
        '{5'd2, '{8'h01,8'h77,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}, 5'd4, '{8'h02,8'h02,8'h01,8'h77,8'h00,8'h00,8'h00,8'h00}},
        '{5'd3, '{8'h01,8'h0E,8'h01,8'h00,8'h00,8'h00,8'h00,8'h00}, 5'd3, '{8'h01,8'h00,8'h0E,8'h00,8'h00,8'h00,8'h00,8'h00}},
        '{5'd2, '{8'h01,8'h21,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}, 5'd4, '{8'h02,8'h05,8'h01,8'h21,8'h00,8'h00,8'h00,8'h00}},
        '{5'd3, '{8'h01,8'h03,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}, 5'd4, '{8'h02,8'h05,8'h01,8'h03,8'h00,8'h00,8'h00,8'h00}},
        '{5'd4, '{8'h01,8'h01,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00}, 5'd4, '{8'h02,8'h05,8'h01,8'h01,8'h00,8'h00,8'h00,8'h00}},
        '{5'd3, '{8'h01,8'h0A,8'h01,8'h00,8'h00,8'h00,8'h00,8'h00}, 5'd4, '{8'h02,8'h05,8'h01,8'h0A,8'h00,8'h00,8'h00,8'h00}}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load_tx(input logic [4:0] n, input logic [0:7][7:0] d);
        tx_len = n;
        for (int i = 0; i < 16; i++) tx[i] = (i < 8) ? d[i] : 8'h00;
    endtask

    // One cycle of selected inputs; returns at the negedge after the edge
    task automatic pulse(input bit rq, input bit bd, input bit pv);
        @(negedge clk);
        req_valid = rq;
        req_len   = tx_len;
        for (int i = 0; i < 16; i++) req_data[8*i +: 8] = tx[i];
        bus_done   = bd;
        poll_valid = pv;
        @(negedge clk);
        req_valid  = 1'b0;
        req_data   = '0;
        bus_done   = 1'b0;
        poll_valid = 1'b0;
    endtask

    task automatic expect_rsp(input string req, input int elen, input logic [0:7][7:0] e);
        check({req, " valid"}, 64'(rsp_valid), 64'd1);
        check({req, " length"}, 64'(rsp_len), 64'(elen));
        for (int i = 0; i < elen; i++)
            check({req, " byte"}, 64'(rsp_data[8*i +: 8]), 64'(e[i]));
        @(negedge clk);
        check("R2 valid drops after one cycle", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 ap_enable", 64'(ap_enable), 64'd0);
        check("R1 ap_rate", 64'(ap_rate), 64'd11);
        check("R1 ap_mask", 64'(ap_mask), 64'd0);
        load_tx(5'd2, '{8'h01,8'h03,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 0, 0);
        expect_rsp("R1 R6 epoch get-time", 7, '{8'h01,8'h00,8'h03,8'h7C,8'h25,8'hB0,8'h80,8'h00});

        // Table walk: R3 R4 R5 R8
        for (int k = 0; k < NV; k++) begin
            load_tx(VEC[k].len, VEC[k].d);
            pulse(1, 0, 0);
            check("R9 no power pulse from vector", 64'(pwr_down_req), 64'd0);
            expect_rsp("R3 R4 R5 R8 vector", int'(VEC[k].elen), VEC[k].e);
        end
        check("R8 enable after table", 64'(ap_enable), 64'd1);
        check("R8 rate after table", 64'(ap_rate), 64'h20);
        check("R8 mask high byte first", 64'(ap_mask), 64'hA53C);

        // R11: poll report while enabled, then ignored while disabled
        poll_len = 4'd3; poll_data = 64'h0000_0000_00CC_BBAA;
        pulse(0, 0, 1);
        expect_rsp("R11 autopoll report", 5, '{8'h00,8'h40,8'hAA,8'hBB,8'hCC,8'h00,8'h00,8'h00});
        load_tx(5'd3, '{8'h01,8'h01,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 0, 0);
        expect_rsp("R8 autopoll off", 3, '{8'h01,8'h00,8'h01,8'h00,8'h00,8'h00,8'h00,8'h00});
        check("R8 enable cleared by zero", 64'(ap_enable), 64'd0);
        pulse(0, 0, 1);
        check("R11 poll ignored when disabled", 64'(rsp_valid), 64'd0);

        // R10: bus forwarding and completions
        load_tx(5'd3, '{8'h00,8'h2C,8'h5A,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 0, 0);
        check("R10 bus_go", 64'(bus_go), 64'd1);
        check("R10 bus_cmd", 64'(bus_cmd), 64'h2C);
        check("R10 bus_args", 64'(bus_args[7:0]), 64'h5A);
        check("R10 no immediate reply", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        check("R10 bus_go one cycle", 64'(bus_go), 64'd0);
        bus_code = 8'h00; bus_len = 4'd2; bus_data = 64'h0000_0000_0000_BBAA;
        pulse(0, 1, 0);
        expect_rsp("R10 bus success", 4, '{8'h00,8'h00,8'hAA,8'hBB,8'h00,8'h00,8'h00,8'h00});
        bus_code = 8'h03;
        pulse(0, 1, 0);
        expect_rsp("R10 bus failure", 3, '{8'h00,8'h03,8'h2C,8'h00,8'h00,8'h00,8'h00,8'h00});

        // R12: other types and short command packets
        load_tx(5'd3, '{8'h03,8'h01,8'h02,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 0, 0);
        check("R12 type 3 silent", 64'(rsp_valid), 64'd0);
        load_tx(5'd1, '{8'h01,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 0, 0);
        check("R12 short command silent", 64'(rsp_valid), 64'd0);

        // R13: request beats bus completion and poll in the same cycle
        load_tx(5'd3, '{8'h01,8'h01,8'h01,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 0, 0);
        expect_rsp("R8 autopoll on", 3, '{8'h01,8'h00,8'h01,8'h00,8'h00,8'h00,8'h00,8'h00});
        load_tx(5'd2, '{8'h01,8'h55,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 1, 1);
        expect_rsp("R13 request wins", 4, '{8'h02,8'h02,8'h01,8'h55,8'h00,8'h00,8'h00,8'h00});
        bus_code = 8'h00; bus_len = 4'd1;
        pulse(0, 1, 1);
        expect_rsp("R13 bus beats poll", 3, '{8'h00,8'h00,8'hAA,8'h00,8'h00,8'h00,8'h00,8'h00});

        // R6 R7: set-time, read back, then count
        load_tx(5'd6, '{8'h01,8'h09,8'h12,8'h34,8'h56,8'h78,8'h00,8'h00});
        pulse(1, 0, 0);
        expect_rsp("R6 set-time ack", 3, '{8'h01,8'h00,8'h09,8'h00,8'h00,8'h00,8'h00,8'h00});
        load_tx(5'd2, '{8'h01,8'h03,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 0, 0);
        expect_rsp("R6 get-time after set", 7, '{8'h01,8'h00,8'h03,8'h12,8'h34,8'h56,8'h78,8'h00});
        repeat (350) @(negedge clk);
        pulse(1, 0, 0);
        expect_rsp("R7 three ticks later", 7, '{8'h01,8'h00,8'h03,8'h12,8'h34,8'h56,8'h7B,8'h00});
        load_tx(5'd5, '{8'h01,8'h09,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 0, 0);
        expect_rsp("R5 set-time short", 4, '{8'h02,8'h05,8'h01,8'h09,8'h00,8'h00,8'h00,8'h00});

        // R9: request pulses and no-effect acknowledgements
        load_tx(5'd2, '{8'h01,8'h0A,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 0, 0);
        check("R9 power-down pulse", 64'(pwr_down_req), 64'd1);
        expect_rsp("R9 power-down ack", 3, '{8'h01,8'h00,8'h0A,8'h00,8'h00,8'h00,8'h00,8'h00});
        check("R9 power-down pulse ends", 64'(pwr_down_req), 64'd0);
        load_tx(5'd2, '{8'h01,8'h11,8'h00,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 0, 0);
        check("R9 reset pulse", 64'(sys_reset_req), 64'd1);
        expect_rsp("R9 reset ack", 3, '{8'h01,8'h00,8'h11,8'h00,8'h00,8'h00,8'h00,8'h00});
        load_tx(5'd3, '{8'h01,8'h21,8'h07,8'h00,8'h00,8'h00,8'h00,8'h00});
        pulse(1, 0, 0);
        expect_rsp("R9 power messages ack", 3, '{8'h01,8'h00,8'h21,8'h00,8'h00,8'h00,8'h00,8'h00});
        check("R9 rate untouched", 64'(ap_rate), 64'h20);
        check("R9 mask untouched", 64'(ap_mask), 64'hA53C);
        check("R9 enable untouched", 64'(ap_enable), 64'd1);

        // R1: reset again clears the registers
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        check("R1 enable after reset", 64'(ap_enable), 64'd0);
        check("R1 rate after reset", 64'(ap_rate), 64'd11);
        check("R1 mask after reset", 64'(ap_mask), 64'd0);

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule